// File: doc/BRIEF.md
# Direct-Mapped Write-Through Byte Cache

This block puts a sixteen-line, one-byte-per-line cache between a CPU-side read/write port and a slower byte-wide main memory that signals completion with a ready pulse. An 8-bit CPU address is split into a line index and a tag. Each line holds a valid flag, the tag and one data byte. The data byte and the tag are read in the same cycle they are addressed, and one shared write strobe updates both.

A small controller serves three flows from an idle state. On a read hit it enables the cache onto the CPU data bus and acknowledges. On a read miss it starts a memory read and waits for ready. It then places the memory byte on the bus, installs the byte and its tag in the line, and acknowledges. Every write, whether it hits or misses, updates the line and is also sent to memory. The acknowledge for a write comes only after memory reports ready. The CPU holds its request until the one-cycle acknowledge. The controller then returns to idle and can accept the next request.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address is served as a miss. While idle after reset, acknowledge, memory start, both bus enables and the cache write strobe are inactive (cache_we_n high).
- R2: The line index is address bits 3:0 and the tag is address bits 7:4. A read hits only when the indexed line is valid and its stored tag equals bits 7:4.
- R3: A read hit acknowledges in the first cycle after the request is sampled. In that cycle cache_bus_en is high, mem_bus_en is low and cpu_rdata carries the cached byte. No memory access is started.
- R4: A read miss raises mem_start for one cycle with mem_we_n high and mem_addr equal to the CPU address. After mem_ready it acknowledges with mem_bus_en high and cpu_rdata equal to the memory byte. The next read of that address hits.
- R5: A write, whether it hits or misses, raises mem_start with mem_we_n low and mem_addr and mem_wdata equal to the CPU address and data. It acknowledges only after mem_ready. A following read of that address hits and returns the new byte.
- R6: Two addresses that share an index evict each other. After one replaces the other, reading the evicted address misses and returns the memory contents.
- R7: cpu_ack lasts exactly one cycle. When read and write are both raised together, the read is served. Requests are only sampled in idle.
- R8: mem_bus_en and cache_bus_en are never high in the same cycle.
- R9: cache_we_n goes low (write) for exactly one cycle of a read miss or a write, which is the acknowledge cycle. It never goes low during a read hit.
- R10: mem_start is a single-cycle pulse, issued once per memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | CPU read request, held until acknowledge |
| cpu_wr | input | 1 | CPU write request, held until acknowledge |
| cpu_addr | input | 8 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Read byte returned to the CPU |
| cpu_ack | output | 1 | One-cycle completion acknowledge |
| mem_start | output | 1 | Memory access start pulse |
| mem_we_n | output | 1 | Memory write select, low for write |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with ready |
| mem_ready | input | 1 | Memory access complete |
| mem_bus_en | output | 1 | Memory byte drives the CPU bus |
| cache_bus_en | output | 1 | Cache byte drives the CPU bus |
| cache_we_n | output | 1 | Cache data and tag write strobe, low for write |

## Verification
The first read after reset, repeated reads of one address and reads at neighbouring indices show whether a cold line, a filled line and a tag mismatch are told apart. Acknowledge latency and bus enable separate the hit path from the miss path. Writes to a line already cached and to a line never read check that both kinds of write allocate and pass through to memory. A write that is later evicted by a conflicting write, and then read back from memory, shows the byte really reached memory. Alternating two addresses on one index checks that each line keeps only the last tag it received.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int ADDR_W_DEF = 8;
    localparam int DATA_W_DEF = 8;
    localparam int IDX_W_DEF  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIT,
        ST_MISS,
        ST_FILL,
        ST_WRITE,
        ST_WACK
    } ctl_state_e;
endpackage

// File: rtl/dmc_store.sv
module dmc_store #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  tag,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              hit
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t lines [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_t line_d;
        line_t line_q;

        always_comb begin
            line_d = line_q;
            if (we && (idx == IDX_W'(i))) begin
                line_d.valid = 1'b1;
                line_d.tag   = tag;
                line_d.data  = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q <= '0;
            end else begin
                line_q <= line_d;
            end
        end

        assign lines[i] = line_q;
    end

    line_t sel;
    assign sel     = lines[idx];
    assign rd_data = sel.data;
    assign hit     = sel.valid && (sel.tag == tag);
endmodule

// File: rtl/dmc_ctl.sv
module dmc_ctl
    import dmc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic              hit,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_start,
    output logic              mem_we_n,
    output logic              mem_bus_en,
    output logic              cache_bus_en,
    output logic              cache_we_n,
    output logic              ack,
    output logic              fill_sel,
    output logic [DATA_W-1:0] fill_byte
);
    typedef struct packed {
        ctl_state_e        state;
        logic              start;
        logic [DATA_W-1:0] fill;
    } ctl_regs_t;

    ctl_regs_t r_d;
    ctl_regs_t r_q;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (rd) begin
                    if (hit) begin
                        r_d.state = ST_HIT;
                    end else begin
                        r_d.state = ST_MISS;
                        r_d.start = 1'b1;
                    end
                end else if (wr) begin
                    r_d.state = ST_WRITE;
                    r_d.start = 1'b1;
                end
            end
            ST_MISS: begin
                if (mem_ready) begin
                    r_d.state = ST_FILL;
                    r_d.fill  = mem_rdata;
                end
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    r_d.state = ST_WACK;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, start: 1'b0, fill: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_start    = r_q.start;
    assign mem_we_n     = (r_q.state != ST_WRITE);
    assign mem_bus_en   = (r_q.state == ST_FILL);
    assign cache_bus_en = (r_q.state == ST_HIT);
    assign cache_we_n   = !((r_q.state == ST_FILL) || (r_q.state == ST_WACK));
    assign ack          = (r_q.state == ST_HIT) || (r_q.state == ST_FILL) ||
                          (r_q.state == ST_WACK);
    assign fill_sel     = (r_q.state == ST_FILL);
    assign fill_byte    = r_q.fill;
endmodule

// File: rtl/dmc_datapath.sv
module dmc_datapath #(
    parameter int DATA_W = 8
) (
    input  logic              cache_bus_en,
    input  logic              mem_bus_en,
    input  logic              fill_sel,
    input  logic [DATA_W-1:0] cache_byte,
    input  logic [DATA_W-1:0] fill_byte,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] bus_byte,
    output logic [DATA_W-1:0] line_wdata
);
    always_comb begin
        if (cache_bus_en) begin
            bus_byte = cache_byte;
        end else if (mem_bus_en) begin
            bus_byte = fill_byte;
        end else begin
            bus_byte = '0;
        end
    end

    assign line_wdata = fill_sel ? fill_byte : cpu_wdata;
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int IDX_W  = IDX_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              mem_start,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              mem_bus_en,
    output logic              cache_bus_en,
    output logic              cache_we_n
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  line_idx;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] cache_byte;
    logic [DATA_W-1:0] fill_byte;
    logic [DATA_W-1:0] line_wdata;
    logic              line_hit;
    logic              fill_sel;

    assign line_idx  = cpu_addr[IDX_W-1:0];
    assign line_tag  = cpu_addr[ADDR_W-1:IDX_W];
    assign mem_addr  = cpu_addr;
    assign mem_wdata = cpu_wdata;

    dmc_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (line_idx),
        .tag     (line_tag),
        .we      (!cache_we_n),
        .wdata   (line_wdata),
        .rd_data (cache_byte),
        .hit     (line_hit)
    );

    dmc_ctl #(.DATA_W(DATA_W)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd           (cpu_rd),
        .wr           (cpu_wr),
        .hit          (line_hit),
        .mem_ready    (mem_ready),
        .mem_rdata    (mem_rdata),
        .mem_start    (mem_start),
        .mem_we_n     (mem_we_n),
        .mem_bus_en   (mem_bus_en),
        .cache_bus_en (cache_bus_en),
        .cache_we_n   (cache_we_n),
        .ack          (cpu_ack),
        .fill_sel     (fill_sel),
        .fill_byte    (fill_byte)
    );

    dmc_datapath #(.DATA_W(DATA_W)) u_dp (
        .cache_bus_en (cache_bus_en),
        .mem_bus_en   (mem_bus_en),
        .fill_sel     (fill_sel),
        .cache_byte   (cache_byte),
        .fill_byte    (fill_byte),
        .cpu_wdata    (cpu_wdata),
        .bus_byte     (cpu_rdata),
        .line_wdata   (line_wdata)
    );
endmodule

// File: rtl/dmc_chk.sv
module dmc_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_rd,
    input logic cpu_wr,
    input logic cpu_ack,
    input logic mem_start,
    input logic mem_we_n,
    input logic mem_ready,
    input logic mem_bus_en,
    input logic cache_bus_en,
    input logic cache_we_n
);
    p_one_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_bus_en && cache_bus_en));

    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |=> !mem_start);

    p_wr_ack_after_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_wr && !cpu_rd) |-> $past(mem_ready));

    p_fill_after_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_bus_en |-> $past(mem_ready));

    p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cache_bus_en |-> (!mem_start && mem_we_n && cache_we_n));

    p_line_write_on_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_we_n |-> cpu_ack);
endmodule

bind dm_wt_cache dmc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_rd       (cpu_rd),
    .cpu_wr       (cpu_wr),
    .cpu_ack      (cpu_ack),
    .mem_start    (mem_start),
    .mem_we_n     (mem_we_n),
    .mem_ready    (mem_ready),
    .mem_bus_en   (mem_bus_en),
    .cache_bus_en (cache_bus_en),
    .cache_we_n   (cache_we_n)
);

// File: tb/sim_mem.sv
module sim_mem #(
    parameter int LAT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       we_n,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       ready
);
    logic [7:0] store [256];
    logic [7:0] a_l;
    logic [7:0] d_l;
    logic       we_n_l;
    int         cnt;

    initial begin
        for (int i = 0; i < 256; i++) store[i] = 8'((i * 29 + 7) & 255);
        rdata = '0;
        ready = 1'b0;
        cnt   = 0;
    end

    always @(posedge clk) begin
        ready <= 1'b0;
        if (!rst_n) begin
            cnt <= 0;
        end else if (start) begin
            a_l    <= addr;
            d_l    <= wdata;
            we_n_l <= we_n;
            cnt    <= LAT;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                ready <= 1'b1;
                if (!we_n_l) store[a_l] <= d_l;
                else         rdata      <= store[a_l];
            end
        end
    end
endmodule

// File: tb/sim_dm_wt_cache.sv
module sim_dm_wt_cache;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_ack;
    logic       mem_start;
    logic       mem_we_n;
    logic [7:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    logic       mem_ready;
    logic       mem_bus_en;
    logic       cache_bus_en;
    logic       cache_we_n;

    int total = 0;
    int bad = 0;
    logic [7:0] ref_mem [256];

    always #4 clk = ~clk;

    dm_wt_cache u0 (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ack(cpu_ack), .mem_start(mem_start), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .mem_bus_en(mem_bus_en),
        .cache_bus_en(cache_bus_en), .cache_we_n(cache_we_n)
    );

    sim_mem #(.LAT(4)) u_mem (
        .clk(clk), .rst_n(rst_n), .start(mem_start), .we_n(mem_we_n),
        .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata), .ready(mem_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One CPU access; exp_hit only matters for reads.
    task automatic run_op(input bit is_wr, input logic [7:0] a, input logic [7:0] wd,
                          input bit exp_hit, input string req);
        int  cyc = 0;
        int  starts = 0;
        int  we_low = 0;
        bit  start_ok = 1'b1;
        bit  rd_hit = !is_wr && exp_hit;
        @(negedge clk);
        cpu_rd = !is_wr; cpu_wr = is_wr; cpu_addr = a; cpu_wdata = wd;
        forever begin
            @(negedge clk);
            cyc++;
            if (mem_start) begin
                starts++;
                if (mem_we_n != !is_wr || mem_addr != a || (is_wr && mem_wdata != wd))
                    start_ok = 1'b0;
            end
            if (!cache_we_n) we_low++;
            if (cpu_ack || cyc > 60) break;
        end
        chk(cpu_ack == 1'b1, req, "ack seen", int'(cpu_ack), 1);
        if (!is_wr) begin
            chk(cpu_rdata == ref_mem[a], req, "read byte", cpu_rdata, ref_mem[a]);
            if (exp_hit)
                chk(cache_bus_en && !mem_bus_en, "R3", "cache bus enable on hit",
                    int'({cache_bus_en, mem_bus_en}), 2);
            else
                chk(mem_bus_en && !cache_bus_en, "R4", "memory bus enable on miss",
                    int'({cache_bus_en, mem_bus_en}), 1);
        end
        if (rd_hit) chk(cyc == 1, req, "hit latency", cyc, 1);
        else        chk(cyc >= 4, req, "memory path latency", cyc, 4);
        chk(starts == (rd_hit ? 0 : 1), "R10", "start pulses", starts, rd_hit ? 0 : 1);
        chk(start_ok, is_wr ? "R5" : "R4", "start fields", int'(start_ok), 1);
        chk(we_low == (rd_hit ? 0 : 1), "R9", "line write cycles", we_low, rd_hit ? 0 : 1);
        if (is_wr) ref_mem[a] = wd;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        @(negedge clk);
        chk(!cpu_ack, "R7", "ack one cycle", int'(cpu_ack), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!cpu_ack && !mem_start && !mem_bus_en && !cache_bus_en && cache_we_n,
            "R1", "idle outputs after reset",
            int'({cpu_ack, mem_start, mem_bus_en, cache_bus_en, cache_we_n}), 1);
    endtask

    task automatic t_miss_then_hit;
        run_op(1'b0, 8'h35, 8'h00, 1'b0, "R1");
        run_op(1'b0, 8'h35, 8'h00, 1'b1, "R4");
        run_op(1'b0, 8'h35, 8'h00, 1'b1, "R3");
    endtask

    task automatic t_index_tag;
        run_op(1'b0, 8'h45, 8'h00, 1'b0, "R2");
        run_op(1'b0, 8'h36, 8'h00, 1'b0, "R2");
        run_op(1'b0, 8'h36, 8'h00, 1'b1, "R2");
        run_op(1'b0, 8'h35, 8'h00, 1'b0, "R6");
    endtask

    task automatic t_write_cached;
        run_op(1'b1, 8'h36, 8'hA5, 1'b0, "R5");
        run_op(1'b0, 8'h36, 8'h00, 1'b1, "R5");
    endtask

    task automatic t_write_uncached;
        run_op(1'b1, 8'h9A, 8'h3C, 1'b0, "R5");
        run_op(1'b0, 8'h9A, 8'h00, 1'b1, "R5");
        run_op(1'b1, 8'h2A, 8'h77, 1'b0, "R6");
        run_op(1'b0, 8'h9A, 8'h00, 1'b0, "R5");
    endtask

    task automatic t_conflict;
        run_op(1'b0, 8'h17, 8'h00, 1'b0, "R6");
        run_op(1'b0, 8'h27, 8'h00, 1'b0, "R6");
        run_op(1'b0, 8'h17, 8'h00, 1'b0, "R6");
        run_op(1'b0, 8'h27, 8'h00, 1'b0, "R6");
        run_op(1'b0, 8'h27, 8'h00, 1'b1, "R6");
    endtask

    task automatic t_both_req;
        // R7: read wins when both requests are raised together
        int cyc = 0;
        @(negedge clk);
        cpu_rd = 1'b1; cpu_wr = 1'b1; cpu_addr = 8'h27; cpu_wdata = 8'hEE;
        @(negedge clk);
        cyc++;
        chk(cpu_ack && cache_bus_en && !mem_start, "R7", "read served first",
            int'({cpu_ack, cache_bus_en, mem_start}), 6);
        chk(cpu_rdata == ref_mem[8'h27], "R7", "read byte", cpu_rdata, ref_mem[8'h27]);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        @(negedge clk);
        chk(!cpu_ack && !mem_start, "R7", "no write issued", int'({cpu_ack, mem_start}), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'((i * 29 + 7) & 255);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss_then_hit();
        t_index_tag();
        t_write_cached();
        t_write_uncached();
        t_conflict();
        t_both_req();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R7 watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule